// File: doc/BRIEF.md
# Shared Add/Subtract ALU Datapath

This block is a purely combinational 32-bit arithmetic and logic unit. It takes two operands and a 4-bit operation code. The code comes straight from an instruction field and needs no decode stage before it. The design is arranged so that the carry chain of the adder is the only long path. Every bitwise function is computed at the same time, and a narrow selector picks one of them. A single adder/subtractor handles addition, subtraction and all the comparisons. In subtract mode it inverts the second operand and forces the carry-in to one.

Comparison results come from the difference alone. Less-than is read from the top bit of the difference. Equality uses a zero-detect on the difference. Less-or-equal combines the two. A comparison result sits in bit 0 of the output, and all bits above it are zero. The output is built by two 2-input multiplexers in series. The first picks between the logic result and the comparison result. The second picks between that value and the adder result, so the slowest signal passes through only one mux.

Top module: `shared_addsub_alu`

## Requirements
- R1: Code 4'b0000 gives opA + opB, modulo 2^32.
- R2: Code 4'b0001 gives opA - opB, modulo 2^32.
- R3: Codes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 give the bitwise AND, OR, XOR and NOR of the operands, in that order.
- R4: Code 4'b1001 gives bit 31 of (opA - opB) mod 2^32 in bit 0, with bits 31..1 zero. For example, 0x80000000 compared with 1 gives 0.
- R5: Code 4'b1000 sets bit 0 to 1 exactly when opA equals opB, with the upper bits zero.
- R6: Code 4'b1010 sets bit 0 to 1 when the R4 bit is 1 or the operands are equal, with the upper bits zero.
- R7: Code 4'b1011 sets bit 0 to 1 exactly when the operands differ, with the upper bits zero.
- R8: The unused codes 4'b0010, 4'b0011 and 4'b11xx produce an all-zero result.
- R9: The result depends only on the present inputs and holds no state. It has settled within the same cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, inverted inside the block for subtract and compare |
| opCode | input | 4 | Operation code taken from the instruction field |
| result | output | 32 | Selected result |

## Verification
The hardest cases to reach are those where the top bit of the difference disagrees with the true signed order. This happens when the subtraction overflows, for example 0x80000000 against 1, or 0x7FFFFFFF against all-ones. It also matters when a zero difference and a negative difference must both be told apart for less-or-equal. Random operands almost never produce these cases. The stimulus therefore sweeps every operation code over all pairs drawn from a corner set: zero, one, all-ones, 0x80000000 and 0x7FFFFFFF. Equal pairs are part of that sweep. Random operands and random codes then follow.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'b0000,
    OP_SUB = 4'b0001,
    OP_AND = 4'b0100,
    OP_OR  = 4'b0101,
    OP_XOR = 4'b0110,
    OP_NOR = 4'b0111,
    OP_EQ  = 4'b1000,
    OP_LT  = 4'b1001,
    OP_LE  = 4'b1010,
    OP_NE  = 4'b1011
  } aluOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic       subMode;    // invert second operand, carry-in one
    logic [1:0] logicSel;   // bitwise function pick
    logic [1:0] cmpSel;     // comparison pick
    logic       pickCmp;    // first mux: comparison over logic
    logic       pickArith;  // last mux: adder over first mux
    logic       killSide;   // force the non-adder side to zero
  } aluStrobeS;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluStrobeS  strb
);

  always_comb begin
    strb          = '0;
    strb.logicSel = opCode[1:0];
    strb.cmpSel   = opCode[1:0];
    case (opCode[3:2])
      2'b00: begin
        strb.pickArith = ~opCode[1];
        strb.subMode   = opCode[0];
        strb.killSide  = opCode[1];
      end
      2'b01: begin
        strb.pickCmp = 1'b0;
      end
      2'b10: begin
        strb.pickCmp = 1'b1;
        strb.subMode = 1'b1;
      end
      default: begin
        strb.killSide = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown(opCode)) begin
      // R8
      unused_kills_chk: assert (!(opCode[3:2] == 2'b11) || (strb.killSide && !strb.pickArith));
    end
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subMode,
  output logic [W-1:0] sum
);

  logic [W-1:0] bIn;

  always_comb begin
    bIn = subMode ? ~b : b;
    sum = a + bIn + W'(subMode);
  end

  always_comb begin
    if (!$isunknown({a, b, subMode})) begin
      // R1
      add_mode_chk: assert (subMode || (sum == W'(a + b)));
      // R2
      sub_mode_chk: assert (!subMode || (sum == W'(a - b)));
    end
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] res
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic andB, orB, xorB, norB;
    always_comb begin
      andB = a[i] & b[i];
      orB  = a[i] | b[i];
      xorB = a[i] ^ b[i];
      norB = ~orB;
      case (sel)
        2'b00:   res[i] = andB;
        2'b01:   res[i] = orB;
        2'b10:   res[i] = xorB;
        default: res[i] = norB;
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluStrobeS    strb,
  output logic [W-1:0] res
);

  logic [W-1:0] arithRes;
  logic [W-1:0] logicRes;
  logic [W-1:0] firstMux;
  logic [W-1:0] sideVal;
  logic         diffZero;
  logic         diffNeg;
  logic         cmpBit;

  alu_addsub #(.W(W)) addsub_i (
    .a       (a),
    .b       (b),
    .subMode (strb.subMode),
    .sum     (arithRes)
  );

  alu_logic_unit #(.W(W)) logic_i (
    .a   (a),
    .b   (b),
    .sel (strb.logicSel),
    .res (logicRes)
  );

  always_comb begin
    diffZero = ~|arithRes;
    diffNeg  = arithRes[W-1];
    case (strb.cmpSel)
      2'b00:   cmpBit = diffZero;
      2'b01:   cmpBit = diffNeg;
      2'b10:   cmpBit = diffNeg | diffZero;
      default: cmpBit = ~diffZero;
    endcase
    firstMux = strb.pickCmp ? W'(cmpBit) : logicRes;
    sideVal  = strb.killSide ? '0 : firstMux;
    res      = strb.pickArith ? arithRes : sideVal;
  end

  always_comb begin
    if (!$isunknown({a, b, strb})) begin
      // R6
      le_covers_eq_chk: assert (!(strb.pickCmp && !strb.pickArith && strb.cmpSel == 2'b10 && a == b) || res == W'(1));
    end
  end

endmodule

// File: rtl/shared_addsub_alu.sv
module shared_addsub_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   opCode,
  output logic [W-1:0] result
);

  aluStrobeS strb;

  alu_ctrl ctrl_i (
    .opCode (opCode),
    .strb   (strb)
  );

  alu_datapath #(.W(W)) dp_i (
    .a    (opA),
    .b    (opB),
    .strb (strb),
    .res  (result)
  );

  always_comb begin
    if (!$isunknown({opA, opB, opCode})) begin
      // R4
      lt_upper_zero_chk: assert (opCode != OP_LT || result[W-1:1] == '0);
      // R5
      eq_match_chk: assert (opCode != OP_EQ || result == W'(opA == opB));
      // R7
      ne_match_chk: assert (opCode != OP_NE || result == W'(opA != opB));
      // R8
      unused_zero_chk: assert (!(opCode[3:2] == 2'b11 || opCode[3:1] == 3'b001) || result == '0);
    end
  end

endmodule

// File: tb/shared_addsub_alu_tb.sv
module shared_addsub_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shared_addsub_alu dut_i (
    .opA    (opA),
    .opB    (opB),
    .opCode (opCode),
    .result (result)
  );

  function automatic logic [31:0] refModel(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    longint unsigned d;
    logic [31:0] diff;
    d = (longint'(a) - longint'(b)) & 64'hFFFF_FFFF;
    diff = d[31:0];
    case (op)
      4'b0000: return 32'((longint'(a) + longint'(b)) & 64'hFFFF_FFFF);
      4'b0001: return diff;
      4'b0100: return a & b;
      4'b0101: return a | b;
      4'b0110: return a ^ b;
      4'b0111: return ~(a | b);
      4'b1000: return (a == b) ? 32'd1 : 32'd0;
      4'b1001: return (d >= 64'h8000_0000) ? 32'd1 : 32'd0;
      4'b1010: return ((d >= 64'h8000_0000) || a == b) ? 32'd1 : 32'd0;
      4'b1011: return (a != b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R3";
      4'b1001: return "R4";
      4'b1000: return "R5";
      4'b1010: return "R6";
      4'b1011: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Drive on the rising edge, compare on the following falling edge (R9: same cycle)
  task automatic runOne(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    logic [31:0] exp;
    @(posedge clk);
    opA = a; opB = b; opCode = op;
    exp = refModel(a, b, op);
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tagOf(op), op, a, b, result, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] corners [5];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF;

    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state: all-zero inputs give zero (R1, R9)
    @(negedge clk);
    checks++;
    if (result !== 32'd0) begin
      fails++;
      $display("FAIL R9 reset-state actual=%h expected=%h", result, 32'd0);
    end

    // Directed overflow corner: R4 is 0 for 0x80000000 against 1
    runOne(32'h8000_0000, 32'h1, 4'b1001);
    // R6 equal operands, R8 unused code
    runOne(32'h1234_5678, 32'h1234_5678, 4'b1010);
    runOne(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1100);

    // Every code over every corner pair (R1..R8)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          runOne(corners[i], corners[j], 4'(op));

    // Random operands, equal pairs mixed in
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = ($urandom_range(0, 7) == 0) ? ra : $urandom();
      runOne(ra, rb, 4'($urandom_range(0, 15)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule